// File: doc/BRIEF.md
# Variable-Frame Register Stack Controller

This block runs a circular file of local registers as a procedure stack in which every call reserves exactly the number of registers its routine asks for. A routine with a single local variable takes only two registers, one for the variable and one for the return address. A separate bank of global registers sits beside the stack and is addressed without reference to the stack pointer. The controller tracks two absolute pointers. The stack top counts all registers allocated so far. The base marks the lowest register that is still held on chip. Everything below the base lives in a memory-side stack extension.

When a call would make the on-chip part exceed the file depth, the oldest registers are written out to memory, one per accepted memory cycle, before the new frame is granted. A return releases the frame size it names. It also states how many registers of the caller's frame must be resident, and any of those that were written out are read back, one per cycle, before the controller accepts new work. While either transfer is running, `busy` is high and call, return and local-write requests are ignored.

Top module: `vwin_regstack`

## Requirements
- R1: In reset and in the first cycle after it, `stk_top` and `stk_base` are 0 and `busy`, `err` and `mem_req` are 0.
- R2: An idle call of size s (0..DEPTH) whose result keeps `stk_top - stk_base` at or below DEPTH raises `stk_top` by s on the next edge and makes no memory request; with no request, both pointers hold.
- R3: Local index r (`rd_glob`/`wr_glob` = 0) selects file slot (stk_top - 1 - r) mod DEPTH. Index 0 is the most recently allocated register, and indices wrap around the circular file.
- R4: Global index g (`rd_glob`/`wr_glob` = 1, low log2(NGLOB) bits of the index) addresses a bank whose contents are unaffected by calls, returns, transfers and local writes.
- R5: A call that does not fit writes registers to memory with `mem_we` = 1, at ascending addresses starting from `stk_base`, with the data held in that register. `stk_base` rises by one per transfer until top+s-base equals DEPTH; then `stk_top` becomes top+s.
- R6: A return of size s with caller need n sets `stk_top` to t = top-s on the next edge. If t is below the base, the base drops to t. No transfer occurs when max(t-n, 0) is not below that base.
- R7: Otherwise registers are read from memory with `mem_we` = 0, at descending addresses from base-1 down to max(t-n, 0). Each is written back into its file slot, so that local reads return the values held before the spill.
- R8: While `busy` is 1 (a transfer is running), call, return and local-write requests are ignored, and `mem_req` is 1 only while `busy` is 1.
- R9: A transfer advances only in a cycle where `mem_ready` is 1; otherwise `mem_req` stays high and `stk_base` holds.
- R10: An idle call with size above DEPTH, or a return with size above `stk_top` or need above DEPTH, pulses `err` for one cycle and leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Allocate a frame (wins over ret_req) |
| call_size | input | SW | Registers to allocate |
| ret_req | input | 1 | Release a frame |
| ret_size | input | SW | Registers to release |
| ret_need | input | SW | Caller registers that must be resident after return |
| rd_glob | input | 1 | Read from global bank when 1 |
| rd_idx | input | IW | Read index (stack-relative when local) |
| rd_data | output | DW | Read data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_glob | input | 1 | Write to global bank when 1 |
| wr_idx | input | IW | Write index (stack-relative when local) |
| wr_data | input | DW | Write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | PW | Absolute stack position of the transfer |
| mem_wdata | output | DW | Spilled register value |
| mem_rdata | input | DW | Filled register value, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| busy | output | 1 | Spill or fill in progress |
| err | output | 1 | One-cycle pulse on a rejected request |
| stk_top | output | PW | Absolute stack top |
| stk_base | output | PW | Absolute lowest on-chip position |

## Verification
The hardest state to reach from the ports is a return whose caller registers were pushed out by a later large call, with the file slots those registers occupied already overwritten by the newer frame. Only then does the fill path have to prove that it restores the right values. The stimulus allocates a small frame and tags each register. It then issues a full-depth call with `mem_ready` held low, so that ignored requests can be tried mid-spill. Next it overwrites the reused slots through the new frame, and returns with a need covering the tagged frame. A table of call and return steps also drives the pointers through exact fill, spill past the full point, and a return that lands below the base.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

    typedef enum logic [1:0] {
        VW_IDLE  = 2'd0,
        VW_SPILL = 2'd1,
        VW_FILL  = 2'd2
    } vw_state_e;

    function automatic int unsigned vw_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vwin_ctrl.sv
module vwin_ctrl
    import vwin_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int PW    = 16,
    parameter int SW    = 8,
    parameter int LW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic [SW-1:0] call_size,
    input  logic          ret_req,
    input  logic [SW-1:0] ret_size,
    input  logic [SW-1:0] ret_need,
    input  logic          mem_ready,
    output logic          busy,
    output logic          err,
    output logic [PW-1:0] top,
    output logic [PW-1:0] base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [PW-1:0] mem_addr,
    output logic [LW-1:0] spill_slot,
    output logic          fill_en,
    output logic [LW-1:0] fill_slot
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    typedef struct packed {
        vw_state_e     st;
        logic [PW-1:0] top;
        logic [PW-1:0] base;
        logic [PW-1:0] goal;
        logic          err;
    } ctrl_t;

    ctrl_t r, n;
    logic [PW-1:0] csz, rsz, rnd;
    logic [PW-1:0] new_top, goal_v, base_start, base_dn, base_up;

    assign csz     = PW'(call_size);
    assign rsz     = PW'(ret_size);
    assign rnd     = PW'(ret_need);
    assign base_dn = r.base - ONE_P;
    assign base_up = r.base + ONE_P;

    always_comb begin
        n          = r;
        n.err      = 1'b0;
        new_top    = '0;
        goal_v     = '0;
        base_start = r.base;
        unique case (r.st)
            VW_IDLE: begin
                if (call_req) begin
                    if (csz > DEPTH_P) begin
                        n.err = 1'b1;
                    end else begin
                        new_top = r.top + csz;
                        if ((new_top - r.base) <= DEPTH_P) begin
                            n.top = new_top;
                        end else begin
                            n.goal = new_top;
                            n.st   = VW_SPILL;
                        end
                    end
                end else if (ret_req) begin
                    if ((rsz > r.top) || (rnd > DEPTH_P)) begin
                        n.err = 1'b1;
                    end else begin
                        new_top    = r.top - rsz;
                        goal_v     = (new_top > rnd) ? (new_top - rnd) : '0;
                        base_start = (new_top < r.base) ? new_top : r.base;
                        n.top      = new_top;
                        n.base     = base_start;
                        if (goal_v < base_start) begin
                            n.goal = goal_v;
                            n.st   = VW_FILL;
                        end
                    end
                end
            end
            VW_SPILL: begin
                if (mem_ready) begin
                    n.base = base_up;
                    if ((r.goal - base_up) <= DEPTH_P) begin
                        n.top = r.goal;
                        n.st  = VW_IDLE;
                    end
                end
            end
            VW_FILL: begin
                if (mem_ready) begin
                    n.base = base_dn;
                    if (base_dn == r.goal) begin
                        n.st = VW_IDLE;
                    end
                end
            end
            default: n.st = VW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r.st   <= VW_IDLE;
            r.top  <= '0;
            r.base <= '0;
            r.goal <= '0;
            r.err  <= 1'b0;
        end else begin
            r <= n;
        end
    end

    assign busy       = (r.st != VW_IDLE);
    assign err        = r.err;
    assign top        = r.top;
    assign base       = r.base;
    assign mem_req    = busy;
    assign mem_we     = (r.st == VW_SPILL);
    assign mem_addr   = (r.st == VW_SPILL) ? r.base : base_dn;
    assign spill_slot = r.base[LW-1:0];
    assign fill_slot  = base_dn[LW-1:0];
    assign fill_en    = (r.st == VW_FILL) && mem_ready;

endmodule

// File: rtl/vwin_lfile.sv
module vwin_lfile #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int LW    = 7
) (
    input  logic          clk,
    input  logic          usr_we,
    input  logic [LW-1:0] usr_wslot,
    input  logic [DW-1:0] usr_wdata,
    input  logic          fill_we,
    input  logic [LW-1:0] fill_wslot,
    input  logic [DW-1:0] fill_wdata,
    input  logic [LW-1:0] usr_rslot,
    output logic [DW-1:0] usr_rdata,
    input  logic [LW-1:0] spill_rslot,
    output logic [DW-1:0] spill_rdata
);
    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            slots[fill_wslot] <= fill_wdata;
        end else if (usr_we) begin
            slots[usr_wslot] <= usr_wdata;
        end
    end

    assign usr_rdata   = slots[usr_rslot];
    assign spill_rdata = slots[spill_rslot];

endmodule

// File: rtl/vwin_gfile.sv
module vwin_gfile #(
    parameter int NGLOB = 64,
    parameter int DW    = 32,
    parameter int GW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [GW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [GW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NGLOB];

    always_ff @(posedge clk) begin
        if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/vwin_regstack.sv
module vwin_regstack
    import vwin_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int NGLOB = 64,
    parameter int DW    = 32,
    parameter int PW    = 16,
    localparam int LW   = $clog2(DEPTH),
    localparam int GW   = $clog2(NGLOB),
    localparam int IW   = int'(vw_max(LW, GW)),
    localparam int SW   = LW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic [SW-1:0] call_size,
    input  logic          ret_req,
    input  logic [SW-1:0] ret_size,
    input  logic [SW-1:0] ret_need,
    input  logic          rd_glob,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic          wr_glob,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [PW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy,
    output logic          err,
    output logic [PW-1:0] stk_top,
    output logic [PW-1:0] stk_base
);
    logic [LW-1:0] spill_slot, fill_slot, rd_slot, wr_slot;
    logic          fill_en;
    logic [PW-1:0] rd_pos, wr_pos;
    logic [DW-1:0] lrd, grd;

    vwin_ctrl #(.DEPTH(DEPTH), .PW(PW), .SW(SW), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst),
        .call_req(call_req), .call_size(call_size),
        .ret_req(ret_req), .ret_size(ret_size), .ret_need(ret_need),
        .mem_ready(mem_ready),
        .busy(busy), .err(err), .top(stk_top), .base(stk_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .spill_slot(spill_slot), .fill_en(fill_en), .fill_slot(fill_slot)
    );

    // stack-relative index: 0 is the newest register, higher reaches older
    assign rd_pos  = stk_top - PW'(1) - PW'(rd_idx);
    assign wr_pos  = stk_top - PW'(1) - PW'(wr_idx);
    assign rd_slot = rd_pos[LW-1:0];
    assign wr_slot = wr_pos[LW-1:0];

    vwin_lfile #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_lfile (
        .clk(clk),
        .usr_we(wr_en && !wr_glob && !busy), .usr_wslot(wr_slot), .usr_wdata(wr_data),
        .fill_we(fill_en), .fill_wslot(fill_slot), .fill_wdata(mem_rdata),
        .usr_rslot(rd_slot), .usr_rdata(lrd),
        .spill_rslot(spill_slot), .spill_rdata(mem_wdata)
    );

    vwin_gfile #(.NGLOB(NGLOB), .DW(DW), .GW(GW)) u_gfile (
        .clk(clk),
        .we(wr_en && wr_glob), .waddr(wr_idx[GW-1:0]), .wdata(wr_data),
        .raddr(rd_idx[GW-1:0]), .rdata(grd)
    );

    assign rd_data = rd_glob ? grd : lrd;

endmodule

// File: rtl/vwin_regstack_chk.sv
module vwin_regstack_chk #(
    parameter int DEPTH = 128,
    parameter int PW    = 16,
    parameter int SW    = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          call_req,
    input logic [SW-1:0] call_size,
    input logic          ret_req,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic          busy,
    input logic          err,
    input logic [PW-1:0] stk_top,
    input logic [PW-1:0] stk_base
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);

    a_r5_occupancy: assert property (@(posedge clk) disable iff (rst)
        (stk_base <= stk_top) && ((stk_top - stk_base) <= DEPTH_P));

    a_r8_mem_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r10_oversize_call: assert property (@(posedge clk) disable iff (rst)
        (!busy && call_req && (call_size > DEPTH_S))
        |=> (err && $stable(stk_top) && $stable(stk_base)));

    a_r5_spill_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> (stk_base == $past(stk_base) + PW'(1)));

    a_r7_fill_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (stk_base == $past(stk_base) - PW'(1)));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(stk_base)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !call_req && !ret_req) |=> ($stable(stk_top) && $stable(stk_base)));

endmodule

bind vwin_regstack vwin_regstack_chk #(.DEPTH(DEPTH), .PW(PW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .call_req(call_req), .call_size(call_size),
    .ret_req(ret_req), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .busy(busy), .err(err), .stk_top(stk_top), .stk_base(stk_base)
);

// File: tb/vwin_regstack_test.sv
module vwin_regstack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_req = 1'b0;
    logic [7:0]  call_size = '0;
    logic        ret_req = 1'b0;
    logic [7:0]  ret_size = '0;
    logic [7:0]  ret_need = '0;
    logic        rd_glob = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic        wr_glob = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic        busy, err;
    logic [15:0] stk_top, stk_base;

    logic [31:0] mem_model [256];
    int          xfer_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vwin_regstack uut (
        .clk(clk), .rst(rst),
        .call_req(call_req), .call_size(call_size),
        .ret_req(ret_req), .ret_size(ret_size), .ret_need(ret_need),
        .rd_glob(rd_glob), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_glob(wr_glob), .wr_idx(wr_idx), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .err(err), .stk_top(stk_top), .stk_base(stk_base)
    );

    assign mem_rdata = mem_model[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            xfer_cnt <= xfer_cnt + 1;
            if (mem_we) mem_model[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // op(1)=call, size, need, expected top, expected base, expected transfers
    localparam int NV = 12;
    localparam logic [64:0] VECS [NV] = '{
        {1'b1, 8'd2,   8'd0,  16'd2,   16'd0,   16'd0},
        {1'b1, 8'd100, 8'd0,  16'd102, 16'd0,   16'd0},
        {1'b1, 8'd20,  8'd0,  16'd122, 16'd0,   16'd0},
        {1'b1, 8'd6,   8'd0,  16'd128, 16'd0,   16'd0},
        {1'b1, 8'd10,  8'd0,  16'd138, 16'd10,  16'd10},
        {1'b0, 8'd10,  8'd6,  16'd128, 16'd10,  16'd0},
        {1'b1, 8'd128, 8'd0,  16'd256, 16'd128, 16'd118},
        {1'b0, 8'd128, 8'd6,  16'd128, 16'd122, 16'd6},
        {1'b0, 8'd6,   8'd20, 16'd122, 16'd102, 16'd20},
        {1'b0, 8'd70,  8'd0,  16'd52,  16'd52,  16'd0},
        {1'b0, 8'd2,   8'd10, 16'd50,  16'd40,  16'd10},
        {1'b0, 8'd50,  8'd0,  16'd0,   16'd0,   16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_call(input logic [7:0] s);
        @(negedge clk); call_req = 1'b1; call_size = s;
        @(negedge clk); call_req = 1'b0;
    endtask

    task automatic pulse_ret(input logic [7:0] s, input logic [7:0] n);
        @(negedge clk); ret_req = 1'b1; ret_size = s; ret_need = n;
        @(negedge clk); ret_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic reg_wr(input logic g, input logic [6:0] i, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_glob = g; wr_idx = i; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input string req, input logic g, input logic [6:0] i, input logic [31:0] exp);
        rd_glob = g; rd_idx = i; #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int x0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 top", 32'(stk_top), 32'd0);
        chk("R1 base", 32'(stk_base), 32'd0);
        chk("R1 busy/err/mem_req", {29'd0, busy, err, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {15'd0, stk_top, busy}, 32'd0);

        // table of call/return steps: R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            x0 = xfer_cnt;
            if (VECS[v][64]) pulse_call(VECS[v][63:56]);
            else             pulse_ret(VECS[v][63:56], VECS[v][55:48]);
            wait_idle();
            chk($sformatf("R2/R5/R6/R7 step %0d top", v), 32'(stk_top), 32'(VECS[v][47:32]));
            chk($sformatf("R5/R6/R7 step %0d base", v), 32'(stk_base), 32'(VECS[v][31:16]));
            chk($sformatf("R2/R5/R7 step %0d transfers", v), 32'(xfer_cnt - x0), 32'(VECS[v][15:0]));
        end

        // R2 no request, pointers hold
        repeat (3) @(negedge clk);
        chk("R2 idle hold", {stk_top, stk_base}, 32'd0);

        // R3 tagged frame
        pulse_call(8'd4);
        for (int r = 0; r < 4; r++) reg_wr(1'b0, 7'(r), 32'hA000_0000 + 32'(r));
        for (int r = 0; r < 4; r++) reg_rd("R3 local read", 1'b0, 7'(r), 32'hA000_0000 + 32'(r));

        // R4 globals
        reg_wr(1'b1, 7'd5, 32'h6000_0005);
        reg_wr(1'b1, 7'd63, 32'h6000_003F);
        reg_wr(1'b0, 7'd5, 32'hDEAD_0005);
        reg_rd("R4 global 5 after local write", 1'b1, 7'd5, 32'h6000_0005);

        // R5 R8 R9 spill with stall
        mem_ready = 1'b0;
        x0 = xfer_cnt;
        pulse_call(8'd128);
        chk("R8 busy during spill", {31'd0, busy}, 32'd1);
        chk("R5 first spill address", {15'd0, mem_we, mem_addr}, 32'h0001_0000);
        reg_wr(1'b0, 7'd0, 32'hBAD0_BAD0);
        pulse_call(8'd2);
        pulse_ret(8'd1, 8'd0);
        chk("R9 stalled base", {stk_base, 15'd0, mem_req}, 32'h0000_0001);
        chk("R9 no transfer while not ready", 32'(xfer_cnt - x0), 32'd0);
        mem_ready = 1'b1;
        wait_idle();
        chk("R5/R8 top after spill", 32'(stk_top), 32'd132);
        chk("R5 base after spill", 32'(stk_base), 32'd4);
        chk("R5 spill count", 32'(xfer_cnt - x0), 32'd4);
        for (int a = 0; a < 4; a++)
            chk("R5/R8 spilled data", mem_model[a], 32'hA000_0000 + 32'(3 - a));
        reg_rd("R4 global 63 after spill", 1'b1, 7'd63, 32'h6000_003F);

        // R3 reuse of wrapped slots by the new frame
        for (int r = 0; r < 4; r++) reg_wr(1'b0, 7'(r), 32'hC000_0000 + 32'(r));
        reg_rd("R3 wrapped slot read", 1'b0, 7'd0, 32'hC000_0000);

        // R7 fill back the tagged frame
        x0 = xfer_cnt;
        pulse_ret(8'd128, 8'd4);
        chk("R7 first fill address", {15'd0, mem_we, mem_addr}, 32'd3);
        wait_idle();
        chk("R7 fill count", 32'(xfer_cnt - x0), 32'd4);
        chk("R7 pointers after fill", {stk_top, stk_base}, {16'd4, 16'd0});
        for (int r = 0; r < 4; r++) reg_rd("R7 restored data", 1'b0, 7'(r), 32'hA000_0000 + 32'(r));

        // R10 rejected requests
        pulse_call(8'd129);
        chk("R10 err oversize call", {31'd0, err}, 32'd1);
        chk("R10 top unchanged", 32'(stk_top), 32'd4);
        @(negedge clk);
        chk("R10 err one cycle", {31'd0, err}, 32'd0);
        pulse_ret(8'd5, 8'd0);
        chk("R10 err return above top", {err, 15'd0, stk_top}, 32'h8000_0004);
        pulse_ret(8'd1, 8'd129);
        chk("R10 err need above depth", {err, 15'd0, stk_top}, 32'h8000_0004);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule